// File: doc/BRIEF.md
# TFT Drawing Window and Orientation Sequencer

This block turns a rectangle request into the byte stream that opens a drawing window on a serial TFT panel controller. Each request gives a first and last column, a first and last row, a 2-bit rotation code and a colour-order select. The block emits a column-range frame, a row-range frame and a memory-write command. Every coordinate goes out as two bytes, upper byte first. Each byte carries a flag that tells command bytes from parameter bytes. Bytes leave over a valid/ready handshake, so a downstream serial shifter can pace them. The panel's native size is 240 columns by 320 rows.

A memory-access orientation frame may come before the window frames. It is sent on the first request after reset, and after that only when the rotation code or the colour-order select differs from the previous request. This keeps repeated window updates as short as possible. The pixel stream that follows the memory-write command is handled elsewhere.

Top module: `tft_window_setter`

## Requirements
- R1: While reset is applied, and until the first request, `busy` and `out_valid` are 0.
- R2: The column frame is command byte 0x2A (`out_is_data`=0), followed by four parameter bytes (`out_is_data`=1): first-column upper byte, first-column lower byte, last-column upper byte, last-column lower byte.
- R3: The row frame follows the column frame. It is command byte 0x2B, followed by the first row and then the last row as four parameter bytes, each row upper byte first.
- R4: The sequence ends with command byte 0x2C, which has no parameters. `busy` is 0 in the cycle after that byte is accepted.
- R5: The orientation frame (command 0x36 plus one parameter byte) comes before the column frame. It is sent on the first request after reset, and on any request whose rotation code or colour-order select differs from the one accepted before. Otherwise it is left out.
- R6: The orientation parameter depends on the rotation code. Code 0 (0°) gives 0x40, code 1 (90°) gives 0xE0, code 2 (180°) gives 0x80 and code 3 (270°) gives 0x30. Bits 2..0 are always 0.
- R7: Bit 3 of the orientation parameter equals `cfg_bgr` as it was when the request was accepted, for every rotation code.
- R8: A request is taken only while `busy` is 0. A `req_valid` seen while `busy` is 1 has no effect on the bytes sent, and no second sequence starts once `req_valid` has been dropped.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_byte` and `out_is_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Window request strobe, taken when busy is 0 |
| req_col_first | input | COORD_W | First column of the window |
| req_col_last | input | COORD_W | Last column of the window |
| req_row_first | input | COORD_W | First row of the window |
| req_row_last | input | COORD_W | Last row of the window |
| req_rot | input | 2 | Rotation code: 0=0°, 1=90°, 2=180°, 3=270° |
| cfg_bgr | input | 1 | Colour-order select placed in the orientation parameter |
| busy | output | 1 | High from acceptance until the memory-write byte is taken |
| out_valid | output | 1 | Output byte is valid |
| out_byte | output | 8 | Command or parameter byte |
| out_is_data | output | 1 | 0 for a command byte, 1 for a parameter byte |
| out_ready | input | 1 | Downstream accepts the byte this cycle |

## Verification
The first request uses a full-panel window. Because its last row exceeds 255, the upper and lower byte split can be seen. Later windows use distinct upper and lower bytes on every coordinate, so a swapped byte order or swapped first and last values shows up. Each of the four rotation codes is sent with both colour-order values. The runs are ordered so that a repeat, a rotation-only change and a colour-only change each land on a request, which separates "orientation sent" from "orientation skipped". Stalled downstream readiness and a request strobe held through a busy sequence show that bytes hold under back-pressure and that late requests are dropped.

// File: rtl/tftw_pkg.sv
package tftw_pkg;
  localparam logic [7:0] CMD_COL_RANGE = 8'h2A;
  localparam logic [7:0] CMD_ROW_RANGE = 8'h2B;
  localparam logic [7:0] CMD_MEM_WRITE = 8'h2C;
  localparam logic [7:0] CMD_ORIENT    = 8'h36;

  // bit positions inside the orientation parameter
  localparam int OB_ROW_ORDER = 7;
  localparam int OB_COL_ORDER = 6;
  localparam int OB_SWAP_XY   = 5;
  localparam int OB_VSCAN     = 4;
  localparam int OB_COLOR_ORD = 3;
  localparam int OB_HSCAN     = 2;

  typedef enum logic [3:0] {
    ST_ORI_CMD, ST_ORI_PAR,
    ST_COL_CMD, ST_COL_FH, ST_COL_FL, ST_COL_LH, ST_COL_LL,
    ST_ROW_CMD, ST_ROW_FH, ST_ROW_FL, ST_ROW_LH, ST_ROW_LL,
    ST_MEM_CMD
  } step_e;
endpackage

// File: rtl/tftw_orient_enc.sv
module tftw_orient_enc
  import tftw_pkg::*;
(
  input  logic [1:0] rot,
  input  logic       bgr,
  output logic [7:0] code
);
  always_comb begin
    code = '0;
    unique case (rot)
      2'd0: code[OB_COL_ORDER] = 1'b1;
      2'd1: begin
        code[OB_ROW_ORDER] = 1'b1;
        code[OB_COL_ORDER] = 1'b1;
        code[OB_SWAP_XY]   = 1'b1;
      end
      2'd2: code[OB_ROW_ORDER] = 1'b1;
      default: begin
        code[OB_SWAP_XY] = 1'b1;
        code[OB_VSCAN]   = 1'b1;
      end
    endcase
    code[OB_HSCAN]     = 1'b0;
    code[OB_COLOR_ORD] = bgr;
  end
endmodule

// File: rtl/tftw_byte_mux.sv
module tftw_byte_mux
  import tftw_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  step_e              step,
  input  logic [COORD_W-1:0] col_first,
  input  logic [COORD_W-1:0] col_last,
  input  logic [COORD_W-1:0] row_first,
  input  logic [COORD_W-1:0] row_last,
  input  logic [7:0]         orient_code,
  output logic [7:0]         byte_o,
  output logic               is_data
);
  localparam int WIDE_W = 16;

  logic [WIDE_W-1:0] cf_w, cl_w, rf_w, rl_w;

  assign cf_w = WIDE_W'(col_first);
  assign cl_w = WIDE_W'(col_last);
  assign rf_w = WIDE_W'(row_first);
  assign rl_w = WIDE_W'(row_last);

  always_comb begin
    is_data = 1'b1;
    unique case (step)
      ST_ORI_CMD: begin byte_o = CMD_ORIENT;    is_data = 1'b0; end
      ST_ORI_PAR: byte_o = orient_code;
      ST_COL_CMD: begin byte_o = CMD_COL_RANGE; is_data = 1'b0; end
      ST_COL_FH:  byte_o = cf_w[15:8];
      ST_COL_FL:  byte_o = cf_w[7:0];
      ST_COL_LH:  byte_o = cl_w[15:8];
      ST_COL_LL:  byte_o = cl_w[7:0];
      ST_ROW_CMD: begin byte_o = CMD_ROW_RANGE; is_data = 1'b0; end
      ST_ROW_FH:  byte_o = rf_w[15:8];
      ST_ROW_FL:  byte_o = rf_w[7:0];
      ST_ROW_LH:  byte_o = rl_w[15:8];
      ST_ROW_LL:  byte_o = rl_w[7:0];
      default:    begin byte_o = CMD_MEM_WRITE; is_data = 1'b0; end
    endcase
  end
endmodule

// File: rtl/tftw_seq_ctrl.sv
module tftw_seq_ctrl
  import tftw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  need_orient,
  input  logic  accept,
  output logic  busy,
  output step_e step
);
  logic  busy_d;
  step_e step_d;

  always_comb begin
    busy_d = busy;
    step_d = step;
    if (!busy) begin
      if (start) begin
        busy_d = 1'b1;
        step_d = need_orient ? ST_ORI_CMD : ST_COL_CMD;
      end
    end else if (accept) begin
      if (step == ST_MEM_CMD) busy_d = 1'b0;
      else                    step_d = step_e'(4'(step) + 4'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= ST_COL_CMD;
    end else begin
      busy <= busy_d;
      step <= step_d;
    end
  end
endmodule

// File: rtl/tft_window_setter.sv
module tft_window_setter
  import tftw_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [COORD_W-1:0] req_col_first,
  input  logic [COORD_W-1:0] req_col_last,
  input  logic [COORD_W-1:0] req_row_first,
  input  logic [COORD_W-1:0] req_row_last,
  input  logic [1:0]         req_rot,
  input  logic               cfg_bgr,
  output logic               busy,
  output logic               out_valid,
  output logic [7:0]         out_byte,
  output logic               out_is_data,
  input  logic               out_ready
);
  localparam int SYNC_STAGES = 2;

  // reset asserts at once, releases after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  logic [COORD_W-1:0] cf_q, cl_q, rf_q, rl_q;
  logic [1:0]         rot_q;
  logic               bgr_q;
  logic               known_q;
  logic               start, need_orient, accept;
  step_e              step;
  logic [7:0]         orient_code;

  assign start       = req_valid && !busy && rst_int_n;
  assign need_orient = !known_q || (req_rot != rot_q) || (cfg_bgr != bgr_q);
  assign accept      = busy && out_ready;

  // request capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cf_q    <= '0;
      cl_q    <= '0;
      rf_q    <= '0;
      rl_q    <= '0;
      rot_q   <= '0;
      bgr_q   <= 1'b0;
      known_q <= 1'b0;
    end else if (start) begin
      cf_q    <= req_col_first;
      cl_q    <= req_col_last;
      rf_q    <= req_row_first;
      rl_q    <= req_row_last;
      rot_q   <= req_rot;
      bgr_q   <= cfg_bgr;
      known_q <= 1'b1;
    end
  end

  tftw_seq_ctrl u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .need_orient (need_orient),
    .accept      (accept),
    .busy        (busy),
    .step        (step)
  );

  tftw_orient_enc u_enc (
    .rot  (rot_q),
    .bgr  (bgr_q),
    .code (orient_code)
  );

  tftw_byte_mux #(.COORD_W(COORD_W)) u_mux (
    .step        (step),
    .col_first   (cf_q),
    .col_last    (cl_q),
    .row_first   (rf_q),
    .row_last    (rl_q),
    .orient_code (orient_code),
    .byte_o      (out_byte),
    .is_data     (out_is_data)
  );

  assign out_valid = busy;
endmodule

// File: rtl/tft_window_setter_chk.sv
module tft_window_setter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       out_is_data,
  input logic       out_ready
);
  logic acc;
  assign acc = out_valid && out_ready;

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_data)));

  p_cmd_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_data) |->
      (out_byte == 8'h2A || out_byte == 8'h2B || out_byte == 8'h2C || out_byte == 8'h36));

  p_col_param_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !out_is_data && out_byte == 8'h2A) |=> (out_valid && out_is_data));

  p_row_param_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !out_is_data && out_byte == 8'h2B) |=> (out_valid && out_is_data));

  p_end_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !out_is_data && out_byte == 8'h2C) |=> !busy);

  p_orient_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !out_is_data && out_byte == 8'h36) |=> (out_is_data && out_byte[2:0] == 3'b000));

  p_start_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

bind tft_window_setter tft_window_setter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .busy        (busy),
  .out_valid   (out_valid),
  .out_byte    (out_byte),
  .out_is_data (out_is_data),
  .out_ready   (out_ready)
);

// File: tb/tft_window_setter_tb_top.sv
`timescale 1ns/1ps
module tft_window_setter_tb_top;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [CW-1:0] req_col_first, req_col_last, req_row_first, req_row_last;
  logic [1:0]    req_rot;
  logic          cfg_bgr;
  logic          busy, out_valid, out_is_data, out_ready;
  logic [7:0]    out_byte;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;
  bit  have_last = 0;
  logic [1:0] last_rot;
  logic       last_bgr;

  always #2.5 clk = ~clk;

  tft_window_setter #(.COORD_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_col_first(req_col_first), .req_col_last(req_col_last),
    .req_row_first(req_row_first), .req_row_last(req_row_last),
    .req_rot(req_rot), .cfg_bgr(cfg_bgr), .busy(busy),
    .out_valid(out_valid), .out_byte(out_byte),
    .out_is_data(out_is_data), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] orient_byte(input logic [1:0] rot, input logic bgr);
    logic [7:0] b;
    case (rot)
      2'd0: b = 8'h40;
      2'd1: b = 8'hE0;
      2'd2: b = 8'h80;
      default: b = 8'h30;
    endcase
    b[3] = bgr;
    return b;
  endfunction

  // one window request; stall throttles out_ready, nag holds req_valid during busy
  task automatic run_req(input int cf, input int cl, input int rf, input int rl,
                         input logic [1:0] rot, input logic bgr,
                         input bit stall, input bit nag, input string tag);
    logic [7:0] eb [16];
    bit         ed [16];
    string      er [16];
    int n = 0;
    int got = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic [7:0] prev_b = '0;
    bit prev_d = 0;
    bit send_ori = !have_last || rot != last_rot || bgr != last_bgr;
    if (send_ori) begin
      eb[n] = 8'h36; ed[n] = 0; er[n] = "R5"; n++;
      eb[n] = orient_byte(rot, bgr); ed[n] = 1; er[n] = "R6/R7"; n++;
    end
    eb[n] = 8'h2A; ed[n] = 0; er[n] = "R2"; n++;
    eb[n] = 8'(cf >> 8); ed[n] = 1; er[n] = "R2"; n++;
    eb[n] = 8'(cf);      ed[n] = 1; er[n] = "R2"; n++;
    eb[n] = 8'(cl >> 8); ed[n] = 1; er[n] = "R2"; n++;
    eb[n] = 8'(cl);      ed[n] = 1; er[n] = "R2"; n++;
    eb[n] = 8'h2B; ed[n] = 0; er[n] = "R3"; n++;
    eb[n] = 8'(rf >> 8); ed[n] = 1; er[n] = "R3"; n++;
    eb[n] = 8'(rf);      ed[n] = 1; er[n] = "R3"; n++;
    eb[n] = 8'(rl >> 8); ed[n] = 1; er[n] = "R3"; n++;
    eb[n] = 8'(rl);      ed[n] = 1; er[n] = "R3"; n++;
    eb[n] = 8'h2C; ed[n] = 0; er[n] = "R4"; n++;
    have_last = 1; last_rot = rot; last_bgr = bgr;

    @(negedge clk);
    req_col_first = CW'(cf); req_col_last = CW'(cl);
    req_row_first = CW'(rf); req_row_last = CW'(rl);
    req_rot = rot; cfg_bgr = bgr; req_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    if (nag) begin
      // R8: different request held while busy
      req_col_first = 16'h0A0B; req_col_last = 16'h0C0D;
      req_row_first = 16'h0E0F; req_row_last = 16'h0102;
      req_rot = ~rot; cfg_bgr = ~bgr;
    end else req_valid = 1'b0;
    check(busy === 1'b1, "R8", {tag, " busy after request"}, int'(busy), 1);
    while (busy === 1'b1 && cyc < 200) begin
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (prev_stall)
        check(out_valid && out_byte === prev_b && out_is_data === prev_d, "R9",
              {tag, " byte held under stall"}, int'(out_byte), int'(prev_b));
      if (out_valid && out_ready) begin
        if (got < n) begin
          check(out_byte === eb[got] && out_is_data === ed[got], er[got],
                $sformatf("%s byte %0d {dc,byte}", tag, got),
                int'({out_is_data, out_byte}), int'({ed[got], eb[got]}));
        end
        got++;
      end
      prev_stall = out_valid && !out_ready;
      prev_b = out_byte;
      prev_d = out_is_data;
      if (nag && got == 3) req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    out_ready = 1'b0;
    check(got == n, send_ori ? "R5" : "R5", {tag, " byte count"}, got, n);
    check(busy === 1'b0, "R4", {tag, " busy low after memory write"}, int'(busy), 0);
    @(negedge clk);
    check(busy === 1'b0 && out_valid === 1'b0, "R8", {tag, " no restart"},
          int'({busy, out_valid}), 0);
  endtask

  task automatic t_reset();
    check(busy === 1'b0 && out_valid === 1'b0, "R1", "reset outputs",
          int'({busy, out_valid}), 0);
  endtask

  task automatic t_full_panel();
    run_req(0, 239, 0, 319, 2'd0, 1'b0, 0, 0, "full panel rot0");
  endtask

  task automatic t_repeat_orient();
    run_req(16'h0112, 16'h0234, 16'h0356, 16'h0478, 2'd0, 1'b0, 1, 0, "same orient stalled");
  endtask

  task automatic t_rotations();
    run_req(5, 100, 7, 200, 2'd1, 1'b0, 0, 0, "rot1");
    run_req(1, 2, 3, 4, 2'd2, 1'b1, 0, 0, "rot2 bgr");
    run_req(16'h00EF, 16'h0100, 16'h013F, 16'h0001, 2'd3, 1'b1, 1, 0, "rot3 bgr");
    run_req(10, 20, 30, 40, 2'd3, 1'b0, 0, 0, "rot3 bgr change");
    run_req(10, 20, 30, 40, 2'd1, 1'b1, 0, 0, "rot1 bgr");
    run_req(9, 8, 7, 6, 2'd0, 1'b1, 0, 0, "rot0 bgr");
    run_req(3, 3, 5, 5, 2'd2, 1'b0, 0, 0, "rot2");
  endtask

  task automatic t_busy_ignore();
    run_req(16'h00AA, 16'h00BB, 16'h00CC, 16'h00DD, 2'd2, 1'b0, 1, 1, "request while busy");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b0;
    req_col_first = '0; req_col_last = '0; req_row_first = '0; req_row_last = '0;
    req_rot = '0; cfg_bgr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_panel();
    t_repeat_orient();
    t_rotations();
    t_busy_ignore();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule